// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit down counters behind a byte-wide register interface with four addresses. Addresses 0 to 2 reach the count registers of channels 0 to 2. Address 3 takes a control byte. That byte either freezes a snapshot of one channel's count for reading, or sets the channel's byte access order, its counting mode and its number format. Each channel counts down by one on every clock where its own count-enable strobe is high. Its output pin follows the programmed mode.

Reload values are written one byte at a time, in the order the channel's access setting asks for. A channel picks up the new reload value on the first count-enable strobe after the final byte. Reads follow the same byte order. A snapshot holds a stable copy while the counter keeps running. Two modes act on the output: terminal-count mode and rate-generator mode. The other four mode codes are stored but act as terminal-count mode. Each channel counts either in plain binary or in four-digit BCD.

Top module: `pit_core`

## Requirements
- R1: A write to address 3 is a control byte whose bits 7:6 select the channel (00 = channel 0, 01 = channel 1, 10 = channel 2). Writes and reads at address 0, 1 or 2 reach only channel 0, 1 or 2 respectively.
- R2: Control bits 5:4 are the access code. 01 = low byte only, and a data write clears the high byte of the reload. 10 = high byte only, and a data write clears the low byte. 11 = low byte first, then high byte. Reads of the count use the same byte selection and alternation.
- R3: Access code 00 copies the selected channel's count into a snapshot. Reads return the snapshot while the counter keeps counting. The snapshot is released after the last read of the access sequence. A further access-code-00 command received while a snapshot is held has no effect.
- R4: A control byte with a nonzero access code stores the access, mode (bits 3:1) and format (bit 0). It resets both byte toggles to "low next" and stops counting. It sets the output to its initial level: high for mode 2, low for every other mode. The reload is taken into the counter on the first count-enable strobe after the final byte of the reload has been written.
- R5: In binary format a running counter decreases by exactly one on each clock with its count-enable high, and holds its value otherwise.
- R6: With bit 0 set, the counter decrements as four BCD digits with borrow between digits, and 0000 decrements to 9999.
- R7: A reload value of 0 gives 65536 strobes to terminal count in binary and 10000 in BCD.
- R8: Mode 0: the output goes low when the last reload byte is written and goes high on the strobe that brings the count to zero. It stays high until the channel is reprogrammed.
- R9: Mode 2: the output goes low on the strobe that brings the count to 1. On the next strobe it returns high and the counter reloads, so the output repeats with a period of N strobes.
- R10: Mode codes 1, 3, 4 and 5 produce the same output and counting behaviour as mode 0.
- R11: Count-enable strobes, control bytes and data accesses aimed at one channel leave the count, output and snapshot of the other channels unchanged.
- R12: After reset every output is low, every count reads 0, and every channel uses low-then-high access, mode 0 and binary format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 to 2 select a channel, 3 selects the control port |
| wr_en | input | 1 | Write strobe, one clock per byte |
| rd_en | input | 1 | Read strobe, one clock per byte; read side effects take place at the clock edge |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational from addr and channel state |
| cen | input | 3 | Per-channel count-enable strobe |
| tmr_out | output | 3 | Per-channel timer output |

## Verification
A byte toggle stuck on the wrong half shows up at the very next read or reload. The count then reads with swapped bytes, or the output switches hundreds of strobes away from where it should. A snapshot that is taken again, or released too early, returns a live byte on the following read. A wrong BCD borrow shows up as a non-decimal digit at the first read after the count passes a digit boundary. A reload that is picked up too early changes the count that reads back before the final byte is written.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int CNT_W  = 16;
  localparam int DIGITS = CNT_W / 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_BOTH = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    MD_TERM   = 3'd0,
    MD_SHOT   = 3'd1,
    MD_RATE   = 3'd2,
    MD_SQUARE = 3'd3,
    MD_SWSTB  = 3'd4,
    MD_HWSTB  = 3'd5,
    MD_RSV6   = 3'd6,
    MD_RSV7   = 3'd7
  } mode_e;

  // Decimal down-step over DIGITS nibbles, borrowing upward; 0..0 gives 9..9.
  function automatic logic [CNT_W-1:0] bcd_dec(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic brw;
    r   = v;
    brw = 1'b1;
    for (int k = 0; k < DIGITS; k++) begin
      if (brw) begin
        if (v[4*k +: 4] == 4'd0) begin
          r[4*k +: 4] = 4'd9;
        end else begin
          r[4*k +: 4] = v[4*k +: 4] - 4'd1;
          brw = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] v,
                                                  input logic bcd);
    return bcd ? bcd_dec(v) : (v - CNT_W'(1));
  endfunction

  function automatic logic bcd_ok(input logic [CNT_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++) begin
      if (v[4*k +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        sel,
  output logic [NUM_CH-1:0] ctl_we,
  output logic [NUM_CH-1:0] port_we,
  output logic [NUM_CH-1:0] port_re
);

  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

  logic ctl_hit;
  assign ctl_hit = wr_en && (addr == CTL_ADDR);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign port_we[i] = wr_en && (addr == ADDR_W'(i));
    assign port_re[i] = rd_en && (addr == ADDR_W'(i));
    assign ctl_we[i]  = ctl_hit && (sel == 2'(i));
  end

  // R1: any single bus write reaches at most one channel target
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_we, port_we}));

  // R1: a control write never also lands on a data port
  p_ctl_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctl_we) |-> (port_we == '0));

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  acc_e              ctl_acc,
  input  mode_e             ctl_mode,
  input  logic              ctl_bcd,
  input  logic              port_we,
  input  logic              port_re,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              cen,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              out_o
);

  acc_e             acc_q;
  mode_e            mode_q;
  logic             bcd_q;
  logic [CNT_W-1:0] reload_q, count_q, snap_q;
  logic             snap_v, wr_hi, rd_hi, pend, run, out_q;

  // named internal events
  logic             snap_cmd, mode_cmd, wr_last, rd_last;
  logic             load_now, step, rate_mode, hit_one, hit_zero, pre_pulse;
  logic [CNT_W-1:0] cnt_dec, rd_src;

  assign snap_cmd  = ctl_we && (ctl_acc == ACC_SNAP);
  assign mode_cmd  = ctl_we && (ctl_acc != ACC_SNAP);
  assign wr_last   = port_we && ((acc_q != ACC_BOTH) || wr_hi);
  assign rd_last   = port_re && ((acc_q != ACC_BOTH) || rd_hi);
  assign load_now  = cen && pend;
  assign step      = cen && run && !pend;
  assign rate_mode = (mode_q == MD_RATE);
  assign cnt_dec   = count_next(count_q, bcd_q);
  assign hit_one   = step && rate_mode && (count_q == CNT_W'(1));
  assign pre_pulse = step && rate_mode && (cnt_dec == CNT_W'(1));
  assign hit_zero  = step && !rate_mode && (cnt_dec == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= ACC_BOTH;
      mode_q   <= MD_TERM;
      bcd_q    <= 1'b0;
      reload_q <= '0;
      count_q  <= '0;
      snap_q   <= '0;
      snap_v   <= 1'b0;
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
      pend     <= 1'b0;
      run      <= 1'b0;
      out_q    <= 1'b0;
    end else if (mode_cmd) begin
      acc_q  <= ctl_acc;
      mode_q <= ctl_mode;
      bcd_q  <= ctl_bcd;
      wr_hi  <= 1'b0;
      rd_hi  <= 1'b0;
      snap_v <= 1'b0;
      pend   <= 1'b0;
      run    <= 1'b0;
      out_q  <= (ctl_mode == MD_RATE);
    end else begin
      // counting
      if (load_now) begin
        count_q <= reload_q;
        pend    <= 1'b0;
        run     <= 1'b1;
      end else if (step) begin
        if (hit_one) begin
          count_q <= reload_q;
          out_q   <= 1'b1;
        end else begin
          count_q <= cnt_dec;
          if (pre_pulse) out_q <= 1'b0;
          if (hit_zero)  out_q <= 1'b1;
        end
      end
      // snapshot and read sequencing
      if (port_re) begin
        if (acc_q == ACC_BOTH) rd_hi <= !rd_hi;
        if (rd_last) snap_v <= 1'b0;
      end
      if (snap_cmd && !snap_v) begin
        snap_q <= count_q;
        snap_v <= 1'b1;
      end
      // reload byte sequencing
      if (port_we) begin
        unique case (acc_q)
          ACC_LO:  reload_q <= {{(CNT_W-BYTE_W){1'b0}}, wdata};
          ACC_HI:  reload_q <= {wdata, {(CNT_W-BYTE_W){1'b0}}};
          default: begin
            if (wr_hi) reload_q[CNT_W-1:BYTE_W] <= wdata;
            else       reload_q[BYTE_W-1:0]     <= wdata;
            wr_hi <= !wr_hi;
          end
        endcase
        if (wr_last) begin
          pend <= 1'b1;
          if (!rate_mode) out_q <= 1'b0;
        end
      end
    end
  end

  assign rd_src = snap_v ? snap_q : count_q;

  always_comb begin
    unique case (acc_q)
      ACC_HI:   rd_byte = rd_src[CNT_W-1:BYTE_W];
      ACC_BOTH: rd_byte = rd_hi ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
      default:  rd_byte = rd_src[BYTE_W-1:0];
    endcase
  end

  assign out_o = out_q;

  // R3: a snapshot command while one is held leaves the snapshot untouched
  p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_cmd && snap_v) |=> (snap_q == $past(snap_q)));

  // R4: the pending reload enters the counter on the next strobe
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && !mode_cmd) |=> (run && count_q == $past(reload_q)));

  // R5: a binary step lowers the count by exactly one
  p_bin_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !bcd_q && !hit_one && !mode_cmd) |=> (count_q == CNT_W'($past(count_q) - CNT_W'(1))));

  // R6: a running decimal counter holds only decimal digits
  p_bcd_digits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd_q && run && !pend) |-> bcd_ok(count_q));

  // R8: reaching zero in terminal-count mode raises the output
  p_tc_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_zero && !mode_cmd && !wr_last) |=> out_q);

  // R9: the rate generator reloads and returns high after the low count
  p_rate_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_one && !mode_cmd) |=> (out_q && count_q == $past(reload_q)));

endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NUM_CH-1:0] cen,
  output logic [NUM_CH-1:0] tmr_out
);

  logic [NUM_CH-1:0] ctl_we, port_we, port_re;
  logic [7:0]        rd_bytes [NUM_CH];

  pit_bus_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .sel     (wdata[7:6]),
    .ctl_we  (ctl_we),
    .port_we (port_we),
    .port_re (port_re)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pit_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we[i]),
      .ctl_acc  (acc_e'(wdata[5:4])),
      .ctl_mode (mode_e'(wdata[3:1])),
      .ctl_bcd  (wdata[0]),
      .port_we  (port_we[i]),
      .port_re  (port_re[i]),
      .wdata    (wdata),
      .cen      (cen[i]),
      .rd_byte  (rd_bytes[i]),
      .out_o    (tmr_out[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rdata = rd_bytes[i];
    end
  end

endmodule

// File: tb/pit_core_tb.sv
`timescale 1ns/1ps
module pit_core_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] cen = '0;
  logic [2:0] tmr_out;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  pit_core u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cen(cen), .tmr_out(tmr_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // every task starts and ends on a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    #1;
    check(tag, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick(input logic [2:0] m);
    cen = m;
    @(negedge clk);
    cen = '0;
  endtask

  task automatic chk_bit(input int idx, input logic exp, input string tag);
    #1;
    check(tag, tmr_out[idx], exp);
  endtask

  // vector: hex R O A 0 _ DD EE  (requirement, op, address, data, expected)
  // op 0 write, 1 read and compare, 2 strobe mask DD, 3 compare tmr_out with EE
  localparam int NV = 34;
  localparam logic [31:0] VEC [NV] = '{
    32'h4030_3000,  // R4 ch0 both-bytes mode0 binary
    32'h8300_0000,  // R8 output low after control byte
    32'h2000_0500,  // R2 low byte 05
    32'h2000_0000,  // R2 high byte 00
    32'h4200_0100,  // R4 strobe loads 5
    32'h2100_0005,  // R2 read low
    32'h2100_0000,  // R2 read high
    32'h5200_0100,  // R5 5->4
    32'h5200_0100,  // R5 4->3
    32'h5200_0100,  // R5 3->2
    32'h5200_0100,  // R5 2->1
    32'h5100_0001,  // R5 read 1 low
    32'h5100_0000,  // R5 read 1 high
    32'h8300_0000,  // R8 still low at count 1
    32'h5200_0100,  // R5 1->0
    32'h8300_0001,  // R8 high at zero
    32'h9030_5400,  // R9 ch1 low-only mode2
    32'h9300_0003,  // R9 initial high
    32'h2010_0300,  // R2 reload 3 via low byte
    32'h9200_0200,  // R9 load 3
    32'h9200_0200,  // R9 3->2
    32'h9300_0003,  // R9 high at 2
    32'h9200_0200,  // R9 2->1
    32'h9300_0001,  // R9 low at 1
    32'h9200_0200,  // R9 reload
    32'h9300_0003,  // R9 high again
    32'h2110_0003,  // R2 low-only read
    32'h2030_A000,  // R2 ch2 high-only mode0
    32'h2020_0100,  // R2 high byte 01 -> 0100
    32'h1300_0003,  // R1 only ch2 went low
    32'h2200_0400,  // R2 load 0100
    32'h2200_0400,  // R2 0100->00FF
    32'h2120_0000,  // R2 high-only read 00
    32'h1120_0000   // R1 repeat read, no toggle
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    chk_bit(0, 1'b0, "R12 out0"); chk_bit(1, 1'b0, "R12 out1"); chk_bit(2, 1'b0, "R12 out2");
    rd(2'd0, 8'h00, "R12 ch0 lo"); rd(2'd0, 8'h00, "R12 ch0 hi");
    rd(2'd1, 8'h00, "R12 ch1 lo");

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      string tag;
      op  = VEC[i][27:24];
      tag = $sformatf("R%0d vec%0d", VEC[i][31:28], i);
      case (op)
        4'd0: wr(VEC[i][21:20], VEC[i][15:8]);
        4'd1: rd(VEC[i][21:20], VEC[i][7:0], tag);
        4'd2: tick(VEC[i][10:8]);
        default: begin #1; check(tag, tmr_out, VEC[i][2:0]); end
      endcase
    end

    // R3 snapshot while counting, second snapshot ignored, release after high byte
    wr(2'd3, 8'h30); wr(2'd0, 8'h34); wr(2'd0, 8'h12); tick(3'b001);
    wr(2'd3, 8'h00);
    repeat (3) tick(3'b001);
    wr(2'd3, 8'h00);
    rd(2'd0, 8'h34, "R3 snap lo");
    tick(3'b001);
    rd(2'd0, 8'h12, "R3 snap hi");
    rd(2'd0, 8'h30, "R3 live lo");
    rd(2'd0, 8'h12, "R3 live hi");

    // R6 decimal wrap and digit borrow
    wr(2'd3, 8'h71); wr(2'd1, 8'h02); wr(2'd1, 8'h00);
    tick(3'b010); tick(3'b010); tick(3'b010);
    chk_bit(1, 1'b1, "R6 zero reached");
    tick(3'b010);
    rd(2'd1, 8'h99, "R6 wrap lo"); rd(2'd1, 8'h99, "R6 wrap hi");
    wr(2'd3, 8'h71); wr(2'd1, 8'h00); wr(2'd1, 8'h01);
    tick(3'b010); tick(3'b010);
    rd(2'd1, 8'h99, "R6 borrow lo"); rd(2'd1, 8'h00, "R6 borrow hi");

    // R7 zero reload: binary 65536, BCD 10000
    wr(2'd3, 8'hB0); wr(2'd2, 8'h00); wr(2'd2, 8'h00);
    tick(3'b100);
    for (int k = 0; k < 65535; k++) tick(3'b100);
    chk_bit(2, 1'b0, "R7 bin one short");
    tick(3'b100);
    chk_bit(2, 1'b1, "R7 bin full");
    wr(2'd3, 8'h71); wr(2'd1, 8'h00); wr(2'd1, 8'h00);
    tick(3'b010);
    for (int k = 0; k < 9999; k++) tick(3'b010);
    chk_bit(1, 1'b0, "R7 bcd one short");
    tick(3'b010);
    chk_bit(1, 1'b1, "R7 bcd full");

    // R10 mode code 3 acts as mode 0
    wr(2'd3, 8'h36);
    chk_bit(0, 1'b0, "R10 initial low");
    wr(2'd0, 8'h02); wr(2'd0, 8'h00);
    tick(3'b001); tick(3'b001);
    chk_bit(0, 1'b0, "R10 low at 1");
    tick(3'b001);
    chk_bit(0, 1'b1, "R10 high at 0");

    // R4 control byte resets the write toggle
    wr(2'd3, 8'h30); wr(2'd0, 8'hAA);
    wr(2'd3, 8'h30); wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    tick(3'b001); tick(3'b001); tick(3'b001);
    chk_bit(0, 1'b0, "R4 toggle reset, count 1");
    tick(3'b001);
    chk_bit(0, 1'b1, "R4 toggle reset, count 0");
    // R4 no load before the final byte
    wr(2'd3, 8'h30); wr(2'd0, 8'h02);
    tick(3'b001); tick(3'b001);
    chk_bit(0, 1'b0, "R4 low while partial");
    rd(2'd0, 8'h00, "R4 no early load lo"); rd(2'd0, 8'h00, "R4 no early load hi");
    wr(2'd0, 8'h00);
    tick(3'b001); tick(3'b001);
    chk_bit(0, 1'b0, "R4 count 1");
    tick(3'b001);
    chk_bit(0, 1'b1, "R4 count 0");

    // R11 channels 0 and 2 together, channel 1 untouched
    wr(2'd3, 8'h30); wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    wr(2'd3, 8'hB0); wr(2'd2, 8'h0A); wr(2'd2, 8'h00);
    tick(3'b101);
    repeat (3) tick(3'b101);
    #1; check("R11 outputs", tmr_out, 3'b011);
    rd(2'd2, 8'h07, "R11 ch2 lo"); rd(2'd2, 8'h00, "R11 ch2 hi");
    rd(2'd1, 8'h00, "R11 ch1 lo"); rd(2'd1, 8'h00, "R11 ch1 hi");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule